// File: doc/BRIEF.md
# Forward-Edge Landing Pad Checker

This block sits at the commit point of a small in-order RISC-V core and enforces forward-edge control-flow integrity. For every retiring instruction it receives the instruction word, its PC, a flag that marks an indirect register jump with its source register index, the live value of register x7 and an enable bit for the current privilege level. When an indirect jump retires, the block arms a one-instruction "landing pad expected" state. The next instruction to retire is then inspected. It must be a landing pad, meaning an AUIPC that writes x0. It must sit at a word-aligned address. Its 20-bit label must be zero or match the label held in x7.

If any of these conditions fails, the block raises a one-cycle violation pulse in the same cycle as the offending instruction's retirement, so the pipeline can squash it. Alongside the pulse it drives the software-check exception cause and trap value. Jumps through the return-address registers x1 and x5 are exempt because returns are covered by a separate mechanism. Jumps through x7 are exempt because they are software-guarded far jumps.

Top module: `lpad_guard`

## Requirements
- R1: After reset, and whenever reset is asserted, `pad_pending` is 0 and `viol_pulse` is 0.
- R2: A retiring indirect jump (`rtr_vld`=1, `rtr_ind_jmp`=1) arms the pending state (`pad_pending`=1 on the next cycle) when all of the following hold: `cfi_en`=1, `trap_taken`=0, no landing pad is already pending, and `rtr_rs1` is not an exempt register.
- R3: An indirect jump with `rtr_rs1` equal to 1 or 5 (a return) never arms the pending state.
- R4: An indirect jump with `rtr_rs1` equal to 7 (a software-guarded jump) never arms the pending state.
- R5: While pending, a retiring instruction that is not a landing pad raises `viol_pulse` in that same cycle. A landing pad has opcode bits [6:0] = 7'b0010111 and rd bits [11:7] = 0.
- R6: While pending, a landing pad whose PC bits [1:0] are not 00 raises `viol_pulse`.
- R7: A landing pad whose label (instruction bits [31:12]) is zero passes the check whatever x7 holds.
- R8: A landing pad with a nonzero label passes only if the label equals x7 bits [31:12]; otherwise `viol_pulse` is raised.
- R9: While `viol_pulse` is 1, `exc_cause` = 18 and `exc_tval` = 2. Both are 0 in every other cycle.
- R10: With `cfi_en`=0 the block arms nothing and raises no violation; a landing pad then behaves as a no-op.
- R11: The pending state is cleared by the next retiring instruction, whether it passes or fails. Cycles with `rtr_vld`=0 leave it unchanged.
- R12: `trap_taken`=1 clears the pending state and suppresses both arming and violation in that cycle.
- R13: `viol_pulse` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rtr_vld | input | 1 | An instruction retires this cycle |
| rtr_insn | input | 32 | Retiring instruction word |
| rtr_pc | input | XLEN | PC of the retiring instruction |
| rtr_ind_jmp | input | 1 | Retiring instruction is an indirect register jump |
| rtr_rs1 | input | 5 | Source register index of that jump |
| x7_val | input | XLEN | Current value of register x7 |
| cfi_en | input | 1 | Forward-edge checking enabled at current privilege |
| trap_taken | input | 1 | A trap redirects flow this cycle |
| pad_pending | output | 1 | A landing pad is expected next |
| viol_pulse | output | 1 | Violation on the retiring instruction |
| exc_cause | output | CAUSE_W | Exception cause when violating |
| exc_tval | output | XLEN | Trap value when violating |

## Verification
The assertions check on every cycle the properties that hold regardless of instruction contents. These are the cause and trap-value encoding, the absence of violations when checking is disabled, the dependency of every violation on a pending state, the clearing by traps and by checked instructions, and the single-cycle shape of the pulse. Whether a particular register index is exempt, and whether a given word, address and x7 pairing counts as a valid landing pad, can only be shown by the bench's scenarios. Those scenarios cover each exempt register, misalignment, zero and mismatched labels, non-pad AUIPC, idle cycles and reset while armed.

// File: rtl/lpad_guard_pkg.sv
// Package: shared constants for the landing pad checker.
// Assumes the standard 32-bit base instruction encoding.
package lpad_guard_pkg;
    localparam logic [6:0] OPC_AUIPC    = 7'b0010111;
    localparam int         SWCHK_CAUSE  = 18;
    localparam int         FWD_EDGE_TVAL = 2;
    localparam int         REG_IDX_W    = 5;
endpackage

// File: rtl/lpad_pad_decode.sv
// Module: recognises a landing pad and evaluates its alignment and label match.
// Assumes the caller passes only the PC low bits and the x7 label field.
module lpad_pad_decode
    import lpad_guard_pkg::*;
#(
    parameter int LABEL_W = 20
) (
    input  logic [31:0]        insn,
    input  logic [1:0]         pc_lo,
    input  logic [LABEL_W-1:0] x7_label,
    output logic               pad_ok
);
    localparam int LBL_LSB = 32 - LABEL_W;

    logic               is_pad;
    logic               aligned;
    logic               label_ok;
    logic [LABEL_W-1:0] pad_label;

    // Decode the pad form, alignment and label rule.
    always_comb begin
        pad_label = insn[31:LBL_LSB];
        is_pad    = (insn[6:0] == OPC_AUIPC) && (insn[11:7] == '0);
        aligned   = (pc_lo == 2'b00);
        label_ok  = (pad_label == '0) || (pad_label == x7_label);
        pad_ok    = is_pad && aligned && label_ok;
    end
endmodule

// File: rtl/lpad_rs1_filter.sv
// Module: flags indirect jumps whose source register is on the exempt list.
// Assumes the list is packed as N_EXEMPT register indices, lowest entry first.
module lpad_rs1_filter
    import lpad_guard_pkg::*;
#(
    parameter int                          N_EXEMPT    = 3,
    parameter logic [N_EXEMPT*REG_IDX_W-1:0] EXEMPT_LIST = {5'd7, 5'd5, 5'd1}
) (
    input  logic [REG_IDX_W-1:0] rs1,
    output logic                 exempt
);
    logic [N_EXEMPT-1:0] hit;

    for (genvar g = 0; g < N_EXEMPT; g++) begin : g_cmp
        // Compare against one exempt index.
        always_comb hit[g] = (rs1 == EXEMPT_LIST[g*REG_IDX_W +: REG_IDX_W]);
    end

    // Any match exempts the jump.
    always_comb exempt = |hit;
endmodule

// File: rtl/lpad_arm_ctrl.sv
// Module: holds the "landing pad expected" state between jump and target.
// Assumes arm and check requests are already qualified by the caller.
module lpad_arm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic consume,
    input  logic flush,
    output logic pending
);
    // Set on arm, clear on consume or flush, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (flush)   pending <= 1'b0;
        else if (arm_req) pending <= 1'b1;
        else if (consume) pending <= 1'b0;
    end
endmodule

// File: rtl/lpad_guard.sv
// Module: forward-edge CFI checker at the commit stage.
// Assumes at most one retiring instruction per cycle and XLEN >= 32.
module lpad_guard
    import lpad_guard_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CAUSE_W  = 8,
    parameter int LABEL_W  = 20,
    parameter int N_EXEMPT = 3,
    parameter logic [N_EXEMPT*REG_IDX_W-1:0] EXEMPT_LIST = {5'd7, 5'd5, 5'd1}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rtr_vld,
    input  logic [31:0]          rtr_insn,
    input  logic [XLEN-1:0]      rtr_pc,
    input  logic                 rtr_ind_jmp,
    input  logic [REG_IDX_W-1:0] rtr_rs1,
    input  logic [XLEN-1:0]      x7_val,
    input  logic                 cfi_en,
    input  logic                 trap_taken,
    output logic                 pad_pending,
    output logic                 viol_pulse,
    output logic [CAUSE_W-1:0]   exc_cause,
    output logic [XLEN-1:0]      exc_tval
);
    localparam int LBL_LSB = 32 - LABEL_W;

    logic pad_ok;
    logic exempt;
    logic live;
    logic checking;
    logic arm_req;

    lpad_pad_decode #(.LABEL_W(LABEL_W)) u_dec (
        .insn     (rtr_insn),
        .pc_lo    (rtr_pc[1:0]),
        .x7_label (x7_val[31:LBL_LSB]),
        .pad_ok   (pad_ok)
    );

    lpad_rs1_filter #(.N_EXEMPT(N_EXEMPT), .EXEMPT_LIST(EXEMPT_LIST)) u_flt (
        .rs1    (rtr_rs1),
        .exempt (exempt)
    );

    // Qualify the retiring instruction and derive arm and violation.
    always_comb begin
        live       = rtr_vld && !trap_taken;
        checking   = live && pad_pending;
        arm_req    = live && cfi_en && !pad_pending && rtr_ind_jmp && !exempt;
        viol_pulse = checking && cfi_en && !pad_ok;
    end

    lpad_arm_ctrl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_req (arm_req),
        .consume (checking),
        .flush   (trap_taken),
        .pending (pad_pending)
    );

    // Drive exception info only alongside a violation.
    always_comb begin
        exc_cause = viol_pulse ? CAUSE_W'(SWCHK_CAUSE)  : '0;
        exc_tval  = viol_pulse ? XLEN'(FWD_EDGE_TVAL)   : '0;
    end
endmodule

// File: rtl/lpad_guard_chk.sv
// Module: property checker for lpad_guard, attached by bind.
module lpad_guard_chk #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rtr_vld,
    input logic               cfi_en,
    input logic               trap_taken,
    input logic               pad_pending,
    input logic               viol_pulse,
    input logic [CAUSE_W-1:0] exc_cause,
    input logic [XLEN-1:0]    exc_tval
);
    a_r9_cause_tval: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> (exc_cause == CAUSE_W'(18) && exc_tval == XLEN'(2)));
    a_r9_quiet_info: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_pulse |-> (exc_cause == '0 && exc_tval == '0));
    a_r10_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !cfi_en |-> !viol_pulse);
    a_r5_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> (pad_pending && rtr_vld));
    a_r11_checked_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rtr_vld && pad_pending) |=> !pad_pending);
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtr_vld && !trap_taken && pad_pending) |=> pad_pending);
    a_r12_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> !pad_pending);
    a_r12_trap_no_viol: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> !viol_pulse);
    a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |=> !viol_pulse);
endmodule

bind lpad_guard lpad_guard_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rtr_vld     (rtr_vld),
    .cfi_en      (cfi_en),
    .trap_taken  (trap_taken),
    .pad_pending (pad_pending),
    .viol_pulse  (viol_pulse),
    .exc_cause   (exc_cause),
    .exc_tval    (exc_tval)
);

// File: tb/lpad_guard_tb.sv
module lpad_guard_tb;
    localparam int CLK_PER = 10;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = 8;

    typedef struct packed {
        logic        vld;
        logic        en;
        logic        trap;
        logic        jmp;
        logic [4:0]  rs1;
        logic [31:0] insn;
        logic [31:0] pc;
        logic [31:0] x7;
        logic        viol;
        logic        pend;
    } vec_t;

    localparam logic [31:0] NOP   = 32'h0000_0013;
    localparam logic [31:0] JALR  = 32'h0000_0067;
    localparam logic [31:0] PAD0  = {20'h0, 5'd0, 7'h17};
    localparam logic [31:0] PADL  = {20'hABCDE, 5'd0, 7'h17};
    localparam logic [31:0] AUX3  = {20'h0, 5'd3, 7'h17};
    localparam int NV = 25;

    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b1,1'b0,1'b1,5'd6, JALR,32'h40,32'h0,        1'b0,1'b1}, // R2
        '{1'b1,1'b1,1'b0,1'b0,5'd0, PAD0,32'h100,32'hFFFFF000,1'b0,1'b0}, // R7
        '{1'b1,1'b1,1'b0,1'b1,5'd1, JALR,32'h44,32'h0,        1'b0,1'b0}, // R3
        '{1'b1,1'b1,1'b0,1'b0,5'd0, NOP, 32'h48,32'h0,        1'b0,1'b0}, // R3
        '{1'b1,1'b1,1'b0,1'b1,5'd5, JALR,32'h4C,32'h0,        1'b0,1'b0}, // R3
        '{1'b1,1'b1,1'b0,1'b1,5'd7, JALR,32'h50,32'h0,        1'b0,1'b0}, // R4
        '{1'b1,1'b1,1'b0,1'b1,5'd10,JALR,32'h54,32'h0,        1'b0,1'b1}, // R2
        '{1'b1,1'b1,1'b0,1'b0,5'd0, NOP, 32'h200,32'h0,       1'b1,1'b0}, // R5
        '{1'b1,1'b1,1'b0,1'b1,5'd10,JALR,32'h58,32'h0,        1'b0,1'b1}, // R13
        '{1'b1,1'b1,1'b0,1'b0,5'd0, PAD0,32'h102,32'h0,       1'b1,1'b0}, // R6
        '{1'b1,1'b1,1'b0,1'b1,5'd10,JALR,32'h5C,32'h0,        1'b0,1'b1}, // R2
        '{1'b1,1'b1,1'b0,1'b0,5'd0, PADL,32'h300,32'hABCDE123,1'b0,1'b0}, // R8
        '{1'b1,1'b1,1'b0,1'b1,5'd12,JALR,32'h60,32'h0,        1'b0,1'b1}, // R2
        '{1'b1,1'b1,1'b0,1'b0,5'd0, PADL,32'h304,32'h12345000,1'b1,1'b0}, // R8
        '{1'b1,1'b1,1'b0,1'b1,5'd12,JALR,32'h64,32'h0,        1'b0,1'b1}, // R2
        '{1'b1,1'b1,1'b0,1'b0,5'd0, AUX3,32'h308,32'h0,       1'b1,1'b0}, // R5
        '{1'b1,1'b0,1'b0,1'b1,5'd12,JALR,32'h68,32'h0,        1'b0,1'b0}, // R10
        '{1'b1,1'b0,1'b0,1'b0,5'd0, NOP, 32'h6C,32'h0,        1'b0,1'b0}, // R10
        '{1'b1,1'b1,1'b0,1'b1,5'd12,JALR,32'h70,32'h0,        1'b0,1'b1}, // R2
        '{1'b0,1'b1,1'b0,1'b0,5'd0, NOP, 32'h74,32'h0,        1'b0,1'b1}, // R11
        '{1'b1,1'b1,1'b1,1'b0,5'd0, NOP, 32'h78,32'h0,        1'b0,1'b0}, // R12
        '{1'b1,1'b1,1'b0,1'b1,5'd12,JALR,32'h7C,32'h0,        1'b0,1'b1}, // R2
        '{1'b1,1'b0,1'b0,1'b0,5'd0, NOP, 32'h80,32'h0,        1'b0,1'b0}, // R10
        '{1'b1,1'b1,1'b1,1'b1,5'd12,JALR,32'h84,32'h0,        1'b0,1'b0}, // R12
        '{1'b1,1'b1,1'b0,1'b0,5'd0, PAD0,32'h88,32'h0,        1'b0,1'b0}  // R7
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               rtr_vld, rtr_ind_jmp, cfi_en, trap_taken;
    logic [31:0]        rtr_insn;
    logic [XLEN-1:0]    rtr_pc, x7_val;
    logic [4:0]         rtr_rs1;
    logic               pad_pending, viol_pulse;
    logic [CAUSE_W-1:0] exc_cause;
    logic [XLEN-1:0]    exc_tval;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    lpad_guard #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rtr_vld(rtr_vld), .rtr_insn(rtr_insn),
        .rtr_pc(rtr_pc), .rtr_ind_jmp(rtr_ind_jmp), .rtr_rs1(rtr_rs1),
        .x7_val(x7_val), .cfi_en(cfi_en), .trap_taken(trap_taken),
        .pad_pending(pad_pending), .viol_pulse(viol_pulse),
        .exc_cause(exc_cause), .exc_tval(exc_tval)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        rtr_vld = v.vld; cfi_en = v.en; trap_taken = v.trap; rtr_ind_jmp = v.jmp;
        rtr_rs1 = v.rs1; rtr_insn = v.insn; rtr_pc = v.pc; x7_val = v.x7;
    endtask

    // Drive at negedge, check combinational outputs before the edge, state after.
    task automatic step(input vec_t v, input string req);
        @(negedge clk);
        drive(v);
        #(CLK_PER/4);
        check({req, " viol"}, 32'(viol_pulse), 32'(v.viol));
        check("R9 cause", 32'(exc_cause), v.viol ? 32'd18 : 32'd0);
        check("R9 tval", exc_tval, v.viol ? 32'd2 : 32'd0);
        @(posedge clk);
        #1;
        check({req, " pending"}, 32'(pad_pending), 32'(v.pend));
    endtask

    localparam vec_t IDLE = '{1'b0,1'b1,1'b0,1'b0,5'd0,NOP,32'h0,32'h0,1'b0,1'b0};

    initial begin
        drive(IDLE);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset pending", 32'(pad_pending), 32'd0);
        check("R1 reset viol", 32'(viol_pulse), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) step(TBL[i], "TBL");

        // R1: reset while armed clears the pending state.
        step('{1'b1,1'b1,1'b0,1'b1,5'd9,JALR,32'h90,32'h0,1'b0,1'b1}, "R2");
        @(negedge clk);
        drive(IDLE);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset while armed", 32'(pad_pending), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R13: a violation followed by another non-pad gives a single pulse.
        step('{1'b1,1'b1,1'b0,1'b1,5'd9,JALR,32'h94,32'h0,1'b0,1'b1}, "R2");
        step('{1'b1,1'b1,1'b0,1'b0,5'd0,NOP,32'h98,32'h0,1'b1,1'b0}, "R5");
        step('{1'b1,1'b1,1'b0,1'b0,5'd0,NOP,32'h9C,32'h0,1'b0,1'b0}, "R13");

        // R11: several idle cycles keep the armed state, then a pad consumes it.
        step('{1'b1,1'b1,1'b0,1'b1,5'd31,JALR,32'hA0,32'h0,1'b0,1'b1}, "R2");
        for (int k = 0; k < 3; k++) step('{1'b0,1'b1,1'b0,1'b0,5'd0,NOP,32'h0,32'h0,1'b0,1'b1}, "R11");
        step('{1'b1,1'b1,1'b0,1'b0,5'd0,PADL,32'hA8,32'hABCDE000,1'b0,1'b0}, "R11");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule